// File: doc/BRIEF.md
# Toggle-Based Cross-Domain Strobe Synchronizer

The block carries single-cycle event strobes from a source clock domain into an unrelated destination clock domain. In the source domain, each accepted event flips a toggle flop. That level crosses into the destination domain through a synchronizer chain. In the destination domain, a one-cycle pulse is rebuilt by comparing the synchronized level with a copy delayed by one cycle.

The synchronized level also travels back into the source domain through a second chain. The source compares it with its own toggle level to form a busy flag. While busy is high, new events are dropped rather than queued.

A rising-edge detector sits on the source input. An input that is held high therefore counts as one event, and the toggle cannot run freely. Each domain has its own active-low asynchronous reset.

Top module: `strobe_sync_cdc`

## Requirements
- R1: While either reset is held low, and after both resets release with no input activity, busy_o and strobe_o are 0.
- R2: A single-cycle strobe_i pulse taken while busy_o is 0 yields exactly one strobe_o pulse in the destination domain.
- R3: Every strobe_o pulse is exactly one destination clock cycle wide.
- R4: busy_o is 1 in the source cycle after a strobe_i rising edge is accepted. busy_o rises only after a cycle in which strobe_i was 1.
- R5: busy_o returns to 0 without further input once the level has made the round trip. With a 125 MHz source and a 13 ns destination period, this takes no more than 12 source cycles.
- R6: A strobe_i rising edge that arrives while busy_o is 1 is dropped and does not change the toggle. Over a run, the number of strobe_o pulses equals the number of strobe_i rising edges seen while busy_o was 0.
- R7: strobe_i held high for any number of source cycles counts as one event and gives exactly one strobe_o pulse.
- R8: Only a 0-to-1 transition of strobe_i is an event. If strobe_i rises while busy and stays high after busy_o falls, no further strobe_o pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk_i | input | 1 | Source domain clock |
| src_rst_ni | input | 1 | Source domain asynchronous reset, active low |
| strobe_i | input | 1 | Source event input, edge-detected |
| busy_o | output | 1 | High while an accepted event is still in flight |
| dst_clk_i | input | 1 | Destination domain clock |
| dst_rst_ni | input | 1 | Destination domain asynchronous reset, active low |
| strobe_o | output | 1 | One-cycle destination strobe per accepted event |

## Verification
The hardest situation to reach is an input edge that lands inside the busy window. Close to it is an input that rises during busy and is still high when busy clears, which must not create a late event. The stimulus builds both cases by placing a second rising edge two source cycles after an accepted one, and by following a one-cycle pulse with a long high level. A scoreboard counts the rising edges seen while busy_o was low and compares that count with the destination pulses. The two clocks run at unrelated periods, so the crossing phase keeps changing.

// File: rtl/strobe_sync_pkg.sv
package strobe_sync_pkg;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/strobe_sync_chain.sv
module strobe_sync_chain #(
  parameter int unsigned STAGES = strobe_sync_pkg::DEF_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned N = (STAGES < strobe_sync_pkg::MIN_SYNC_STAGES) ?
                              strobe_sync_pkg::MIN_SYNC_STAGES : STAGES;

  logic [N-1:0] stage_q;

  for (genvar i = 0; i < N; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[i] <= 1'b0;
      else if (i == 0) stage_q[i] <= d_i;
      else stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
    end
  end

  assign q_o = stage_q[N-1];
endmodule

// File: rtl/strobe_sync_src.sv
module strobe_sync_src (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic ack_lvl_i,
  output logic tgl_o,
  output logic busy_o
);
  logic in_q, tgl_q, rise, accept;

  // edge detect: held-high input is one event
  assign rise   = strobe_i & ~in_q;
  assign accept = rise & ~busy_o;
  assign busy_o = tgl_q ^ ack_lvl_i;
  assign tgl_o  = tgl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= 1'b0;
      tgl_q <= 1'b0;
    end else begin
      in_q  <= strobe_i;
      tgl_q <= tgl_q ^ accept;
    end
  end

  assert_busy_after_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(strobe_i));

  assert_hold_when_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(tgl_q));
endmodule

// File: rtl/strobe_sync_dst.sv
module strobe_sync_dst #(
  parameter int unsigned STAGES = strobe_sync_pkg::DEF_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  output logic lvl_o,
  output logic strobe_o
);
  logic lvl_sync, lvl_q;

  strobe_sync_chain #(.STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (tgl_i),
    .q_o   (lvl_sync)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_sync;
  end

  assign strobe_o = lvl_sync ^ lvl_q;
  assign lvl_o    = lvl_sync;

  assert_single_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);

  assert_level_settles_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> $stable(lvl_sync));
endmodule

// File: rtl/strobe_sync_cdc.sv
module strobe_sync_cdc #(
  parameter int unsigned SYNC_STAGES = strobe_sync_pkg::DEF_SYNC_STAGES
) (
  input  logic src_clk_i,
  input  logic src_rst_ni,
  input  logic strobe_i,
  output logic busy_o,
  input  logic dst_clk_i,
  input  logic dst_rst_ni,
  output logic strobe_o
);
  logic tgl, dst_lvl, ack_lvl;

  strobe_sync_src u_src (
    .clk_i    (src_clk_i),
    .rst_ni   (src_rst_ni),
    .strobe_i (strobe_i),
    .ack_lvl_i(ack_lvl),
    .tgl_o    (tgl),
    .busy_o   (busy_o)
  );

  strobe_sync_dst #(.STAGES(SYNC_STAGES)) u_dst (
    .clk_i   (dst_clk_i),
    .rst_ni  (dst_rst_ni),
    .tgl_i   (tgl),
    .lvl_o   (dst_lvl),
    .strobe_o(strobe_o)
  );

  // return path for busy
  strobe_sync_chain #(.STAGES(SYNC_STAGES)) u_ack (
    .clk_i (src_clk_i),
    .rst_ni(src_rst_ni),
    .d_i   (dst_lvl),
    .q_o   (ack_lvl)
  );

  assert_reset_quiet_R1: assert property (@(posedge src_clk_i) disable iff (!src_rst_ni)
    $rose(src_rst_ni) |-> !busy_o);
endmodule

// File: tb/sim_strobe_sync_cdc.sv
module sim_strobe_sync_cdc;
  logic src_clk = 0, dst_clk = 0, src_rst_n = 0, dst_rst_n = 0, strobe = 0;
  logic busy, strobe_out;
  int errors = 0, checks = 0;
  int pulse_cnt = 0, wide_cnt = 0, accept_cnt = 0;
  logic prev_out = 0, prev_in = 0;
  bit done = 0;

  always #4   src_clk = ~src_clk;   // 125 MHz
  always #6.5 dst_clk = ~dst_clk;

  strobe_sync_cdc u0 (
    .src_clk_i(src_clk), .src_rst_ni(src_rst_n), .strobe_i(strobe), .busy_o(busy),
    .dst_clk_i(dst_clk), .dst_rst_ni(dst_rst_n), .strobe_o(strobe_out)
  );

  // {high cycles, low cycles after, expected pulses}
  localparam int VEC [6][3] = '{'{1,30,1}, '{3,30,1}, '{60,30,1},
                                '{1,30,1}, '{20,30,1}, '{2,30,1}};

  // destination scoreboard: count and width
  always @(negedge dst_clk) if (dst_rst_n) begin
    if (strobe_out) pulse_cnt++;
    if (strobe_out && prev_out) wide_cnt++;
    prev_out = strobe_out;
  end

  // source scoreboard: rising edges seen while not busy
  always @(negedge src_clk) if (src_rst_n) begin
    if (strobe && !prev_in && !busy) accept_cnt++;
    prev_in = strobe;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge src_clk);
      strobe = v;
    end
  endtask

  task automatic run(input int hi, input int lo, input int exp, input string req);
    int p0;
    p0 = pulse_cnt;
    drive(1'b1, hi);
    drive(1'b0, lo);
    check(req, pulse_cnt - p0, exp);
    check("R5 busy idle", int'(busy), 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int p0, n;
    repeat (3) @(negedge src_clk);
    check("R1 busy in reset", int'(busy), 0);
    check("R1 strobe in reset", int'(strobe_out), 0);
    src_rst_n = 1;
    dst_rst_n = 1;
    drive(1'b0, 10);
    check("R1 busy idle", int'(busy), 0);
    check("R1 no pulses", pulse_cnt, 0);

    for (int v = 0; v < 6; v++)
      run(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][0] > 1 ? "R7 held high" : "R2 single");

    // R4/R5: busy timing
    @(negedge src_clk);
    strobe = 1;
    @(negedge src_clk);
    strobe = 0;
    check("R4 busy after accept", int'(busy), 1);
    n = 0;
    while (busy && n < 40) begin
      @(negedge src_clk);
      n++;
    end
    check("R5 busy clears", int'(n <= 12), 1);
    drive(1'b0, 20);

    // R6: second edge inside busy window is dropped
    p0 = pulse_cnt;
    drive(1'b1, 1); drive(1'b0, 1); drive(1'b1, 1); drive(1'b0, 30);
    check("R6 drop while busy", pulse_cnt - p0, 1);

    // R8: rise during busy, still high after busy clears
    p0 = pulse_cnt;
    drive(1'b1, 1); drive(1'b0, 1); drive(1'b1, 40); drive(1'b0, 30);
    check("R8 no late event", pulse_cnt - p0, 1);

    // R2: two well-spaced events
    p0 = pulse_cnt;
    drive(1'b1, 1); drive(1'b0, 30); drive(1'b1, 1); drive(1'b0, 30);
    check("R2 two events", pulse_cnt - p0, 2);

    check("R6 scoreboard", pulse_cnt, accept_cnt);
    check("R3 width", wide_cnt, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule